// File: doc/BRIEF.md
# Iterative Ones Counter (Controller plus Datapath)

This block counts how many bits are set in a parallel input word. It does not use an adder tree. A small finite state machine drives a loop in a register datapath. Each pass isolates the lowest bit of a working copy of the word, adds that bit to a running count and shifts the copy one place right. The loop stops as soon as the copy becomes zero, so the run time depends on where the highest set bit of the word lies.

A client holds the word on `word_i` and raises `start_i` for one cycle while the block is idle. When the result is ready, `done_o` pulses for one cycle and `count_o` carries the result. `count_o` keeps that value until the next result is published. A start request that arrives while a computation is running is dropped.

The controller is a state-based machine with six states: idle, load, compare, temp, update and publish. All datapath actions depend on the state alone. The only exception is the strobe that copies the count to the output in the compare state once the word is zero.

Top module: `ones_counter`

## Requirements
- R1: After synchronous reset `done_o` is 0, `count_o` is 0 and the block is idle, so the next start is accepted.
- R2: In idle, a clock edge that samples `start_i` = 1 begins a run. `word_i` is captured on the following clock edge, so it must hold over both edges.
- R3: The published count equals the number of 1 bits in the captured word.
- R4: An all-zero word makes no loop passes and gives a count of 0. `done_o` is high in the cycle after the third clock edge counted from the accepting edge.
- R5: Let P be the index of the highest set bit plus one (P = 0 for a zero word). Then `done_o` is high in the cycle after clock edge 3 + 3·P, counting the accepting edge as edge 1.
- R6: `done_o` is high for exactly one cycle per run, and `count_o` already holds the new result in that cycle.
- R7: Between results, `count_o` does not change, whatever `word_i` does.
- R8: While a run is in progress, `start_i` and changes of `word_i` have no effect on its result or its length.
- R9: The count is $clog2(WIDTH+1) bits wide, and an all-ones word gives exactly WIDTH with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a count (honoured only when idle) |
| word_i | input | WIDTH | Word to be counted |
| count_o | output | $clog2(WIDTH+1) | Number of set bits from the last run |
| done_o | output | 1 | One-cycle pulse when `count_o` is updated |

## Verification
The bench builds the block with the default WIDTH of 16, which makes the count 5 bits wide. At this width the all-ones word reaches the top count value 16, and a word with only the top bit set reaches the longest run of 16 passes, 51 edges. Random words are shifted right by random amounts so that the loop length varies across its whole range. Every run checks both the value and the exact latency. Some runs also have a start request and a different word injected part way through.

// File: rtl/ones_counter_pkg.sv
package ones_counter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_COMPARE = 3'd2,
        ST_TEMP    = 3'd3,
        ST_UPDATE  = 3'd4,
        ST_PUBLISH = 3'd5
    } oc_state_e;

    // Control word from controller to datapath.
    typedef struct packed {
        logic load;     // copy word, clear count, set mask
        logic isolate;  // temp <= data & mask
        logic step;     // count += temp, data >>= 1
        logic publish;  // output register <= count
    } oc_ctl_t;

    function automatic oc_ctl_t decode_ctl(oc_state_e st, logic data_zero);
        oc_ctl_t c;
        c.load    = (st == ST_LOAD);
        c.isolate = (st == ST_TEMP);
        c.step    = (st == ST_UPDATE);
        c.publish = (st == ST_COMPARE) && data_zero;
        return c;
    endfunction

    function automatic oc_state_e next_state(oc_state_e st, logic start, logic data_zero);
        oc_state_e n;
        case (st)
            ST_IDLE:    n = start ? ST_LOAD : ST_IDLE;
            ST_LOAD:    n = ST_COMPARE;
            ST_COMPARE: n = data_zero ? ST_PUBLISH : ST_TEMP;
            ST_TEMP:    n = ST_UPDATE;
            ST_UPDATE:  n = ST_COMPARE;
            ST_PUBLISH: n = ST_IDLE;
            default:    n = ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ones_counter_ctrl.sv
module ones_counter_ctrl
    import ones_counter_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      data_zero_i,
    output oc_ctl_t   ctl_o,
    output oc_state_e state_o,
    output logic      done_o
);

    oc_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= next_state(state_q, start_i, data_zero_i);
    end

    always_comb begin
        ctl_o   = decode_ctl(state_q, data_zero_i);
        done_o  = (state_q == ST_PUBLISH);
        state_o = state_q;
    end

    // R6: the completion flag never lasts two cycles
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4: a zero working word in compare leads straight to completion
    a_r4_zero_exits: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMPARE && data_zero_i) |=> done_o);

    // R8: outside idle a start request never sends the machine to load
    a_r8_busy_start_dropped: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i) |=> state_q != ST_LOAD);

endmodule

// File: rtl/ones_counter_dp.sv
module ones_counter_dp
    import ones_counter_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  oc_ctl_t                    ctl_i,
    input  logic [WIDTH-1:0]           word_i,
    output logic                       data_zero_o,
    output logic [$clog2(WIDTH+1)-1:0] count_o
);

    localparam int CW = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] temp_q;
    logic [CW-1:0]    ocnt_q;
    logic [CW-1:0]    out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mask_q <= '0;
            temp_q <= '0;
            ocnt_q <= '0;
            out_q  <= '0;
        end else begin
            if (ctl_i.load) begin
                data_q <= word_i;
                mask_q <= WIDTH'(1);
                ocnt_q <= '0;
            end
            if (ctl_i.isolate) temp_q <= data_q & mask_q;
            if (ctl_i.step) begin
                ocnt_q <= ocnt_q + CW'(temp_q);
                data_q <= data_q >> 1;
            end
            if (ctl_i.publish) out_q <= ocnt_q;
        end
    end

    assign data_zero_o = (data_q == '0);
    assign count_o     = out_q;

    // R2: loading starts the tally from zero
    a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
        ctl_i.load |=> ocnt_q == '0);

    // R3: a step adds at most one to the tally and shifts the word once
    a_r3_step_increment: assert property (@(posedge clk) disable iff (rst)
        ctl_i.step |=> (ocnt_q == $past(ocnt_q) || ocnt_q == $past(ocnt_q) + CW'(1)));
    a_r3_step_shift: assert property (@(posedge clk) disable iff (rst)
        ctl_i.step |=> data_q == ($past(data_q) >> 1));

    // R7: the output register changes only on a publish strobe
    a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.publish |=> $stable(out_q));

endmodule

// File: rtl/ones_counter.sv
module ones_counter
    import ones_counter_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [WIDTH-1:0]           word_i,
    output logic [$clog2(WIDTH+1)-1:0] count_o,
    output logic                       done_o
);

    localparam int CW = $clog2(WIDTH + 1);

    oc_ctl_t   ctl;
    oc_state_e state;
    logic      data_zero;

    ones_counter_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .data_zero_i (data_zero),
        .ctl_o       (ctl),
        .state_o     (state),
        .done_o      (done_o)
    );

    ones_counter_dp #(.WIDTH(WIDTH)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .ctl_i       (ctl),
        .word_i      (word_i),
        .data_zero_o (data_zero),
        .count_o     (count_o)
    );

    // R9: a published count never exceeds the word width
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        done_o |-> count_o <= CW'(WIDTH));

    // R1: in the cycle after reset the machine is idle and quiet
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE && !done_o));

endmodule

// File: tb/sim_ones_counter.sv
`timescale 1ns/1ps
module sim_ones_counter;

    localparam int W  = 16;
    localparam int CW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [W-1:0]  word_i = '0;
    logic [CW-1:0] count_o;
    logic          done_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ones_counter #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i),
        .count_o(count_o), .done_o(done_o)
    );

    function automatic int ref_ones(logic [W-1:0] w);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic int ref_passes(logic [W-1:0] w);
        int p = 0;
        for (int i = 0; i < W; i++) if (w[i]) p = i + 1;
        return p;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // One run; inject = disturb start_i and word_i while busy (R8)
    task automatic run_word(logic [W-1:0] w, bit inject);
        int cycles;
        int exp_cyc;
        logic [CW-1:0] held;
        exp_cyc = 3 + 3 * ref_passes(w);
        @(negedge clk);
        word_i  = w;
        start_i = 1'b1;
        @(posedge clk);
        cycles = 1;
        @(negedge clk);
        start_i = 1'b0;
        if (inject) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            word_i  = ~w;
            start_i = 1'b1;
            @(posedge clk);
            cycles++;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o && cycles < 3 * W + 20) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
        check(done_o == 1'b1, "R2 run completes", int'(done_o), 1);
        check(int'(count_o) == ref_ones(w), inject ? "R8 count under busy start" : "R3 count",
              int'(count_o), ref_ones(w));
        check(cycles == exp_cyc, inject ? "R8 latency under busy start" : "R5 latency",
              cycles, exp_cyc);
        held = count_o;
        @(negedge clk);
        check(done_o == 1'b0, "R6 done single cycle", int'(done_o), 0);
        for (int k = 0; k < 3; k++) begin
            word_i = W'($urandom());
            @(negedge clk);
            check(count_o == held, "R7 count held", int'(count_o), int'(held));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        check(count_o == '0, "R1 count after reset", int'(count_o), 0);

        // R4 all-zero word: no passes
        run_word('0, 1'b0);
        // R9 all ones reaches WIDTH
        run_word('1, 1'b0);
        check(int'(count_o) == W, "R9 all-ones count", int'(count_o), W);
        // MSB only: longest loop with a single one
        run_word(W'(1) << (W - 1), 1'b0);
        run_word(W'(1), 1'b0);
        run_word(W'(16'h5555), 1'b0);
        run_word(W'(16'hAAAA), 1'b0);
        // R8 busy start with altered word
        run_word(W'(16'h00F3), 1'b1);
        run_word('0, 1'b1);
        run_word('1, 1'b1);

        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] w;
            w = W'($urandom()) >> ($urandom() % W);
            run_word(w, (i % 5) == 0);
        end

        // R1 synchronous reset mid-run returns to idle, next run correct
        @(negedge clk);
        word_i  = W'(16'hFFF0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(done_o == 1'b0 && count_o == '0, "R1 reset mid-run", int'(count_o), 0);
        run_word(W'(16'h0109), 1'b0);

        finish_run();
    end

endmodule